// File: doc/BRIEF.md
# Power-up reset and serial boot-configuration sequencer

This block sits between the board-level reset and power signals and the processor core. It does nothing until the power-good input has been seen high through a short synchronizer. From then on it runs a slow mode clock, which is the system clock divided by a power of two (256 by default). While no valid configuration is held, it shifts one bit per mode-clock period from a single serial data pin into a mode word of parameterized length.

Two active-low reset pins set the kind of reset. With both low, the reset is cold: the captured configuration is thrown away and reloaded after the cold-reset pin is released. With only the reset pin low, the reset is warm: the configuration is kept and only the core is held in reset. The internal core reset is released one clock after a valid mode word is held and both reset pins are high. Asserting the reset pin pulls the core reset down at once, without waiting for a clock edge.

The mode word is a level-held result, not a stream. `mode_valid` qualifies it. There is no ready signal and no back-pressure: a consumer may read the word in any cycle while `mode_valid` is high, and the word holds until the next cold reset or power loss.

Top module: `rstseq_top`

## Requirements
- R1: While `pwr_good` is low, or until it has been high for two clock edges, the block is idle: `mode_clk`=0, `mode_word`=0, `mode_valid`=0, `core_rst_n`=0 and `rst_is_cold`=1, whatever the other inputs do.
- R2: Once idle ends, an internal counter of DIV_LOG2 bits starts at 0 and increments every clock. `mode_clk` is its top bit, so it has a period of 2^DIV_LOG2 clocks (256 by default), is high for half of that period, and first rises 2^(DIV_LOG2-1) clock edges after idle ends.
- R3: At each clock edge where `mode_clk` rises, `mode_din` is sampled while no valid word is held. The k-th sample of a load (counting from 0) ends up in `mode_word[k]`, so the least significant bit comes first. Between rising edges `mode_word` does not change.
- R4: `mode_valid` goes high on the same edge that captures sample MODE_BITS-1. After that, no further bits are sampled and `mode_word` holds.
- R5: `core_rst_n` goes high one clock edge after an edge at which `mode_valid`, `cold_rst_n` and `rst_n` were all high and idle had ended. It is never high while `mode_valid` is low.
- R6: Driving `rst_n` low forces `core_rst_n` low immediately, before the next clock edge.
- R7: A warm reset (`rst_n`=0 with `cold_rst_n`=1 at a clock edge) leaves `mode_word` and `mode_valid` unchanged and drives `rst_is_cold` to 0 from that edge.
- R8: A cold reset (`rst_n`=0 and `cold_rst_n`=0 at a clock edge) clears `mode_valid` and sets `rst_is_cold` to 1. While `cold_rst_n` is low the load stays at bit 0. After release, a fresh load of MODE_BITS bits begins at the next `mode_clk` rise.
- R9: A fall of `pwr_good` at any time returns every output to its R1 idle value at once, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| pwr_good | input | 1 | Supply-stable indication; low forces idle |
| cold_rst_n | input | 1 | Cold-reset qualifier, active low, released synchronously |
| rst_n | input | 1 | Reset request, active low, released synchronously |
| mode_din | input | 1 | Serial configuration data |
| mode_clk | output | 1 | Divided clock that paces the serial data |
| mode_word | output | MODE_BITS | Captured configuration word, bit 0 first in time |
| mode_valid | output | 1 | Mode word is complete |
| rst_is_cold | output | 1 | 1 when the latest reset was cold, 0 after a warm one |
| core_rst_n | output | 1 | Core reset release, active low |

## Verification
The bench targets these corner cases:

- **Warm reset held across several mode-clock rises.** A design that reloads on a warm reset would corrupt the captured word with the new data on the pin.
- **Cold reset held for hundreds of cycles, then released at a known divider phase.** This checks that the load restarts from bit 0. A design that resumed a partial count would shift the new pattern out of place.
- **Power-good dropped in the middle of a load.** This checks the idle values without waiting for a clock.
- **Reset pin dropped mid-cycle.** The core reset must fall before the next edge. A purely synchronous release path would miss this.
- **Core reset timing with the reset pins still held.** The core reset must stay low after `mode_valid` rises while the pins are low. It must rise exactly one edge after release.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  typedef enum logic [1:0] {
    RK_NONE = 2'd0,
    RK_WARM = 2'd1,
    RK_COLD = 2'd2
  } rst_kind_e;

  // Both pins low is a cold reset; the reset pin alone is a warm reset.
  function automatic rst_kind_e classify(input logic cold_n, input logic req_n);
    if (!req_n && !cold_n) return RK_COLD;
    if (!req_n)            return RK_WARM;
    return RK_NONE;
  endfunction

endpackage

// File: rtl/rstseq_pg_sync.sv
module rstseq_pg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic pg_raw,
  output logic pg_ok
);

  generate
    if (STAGES == 1) begin : g_one
      logic q;
      always_ff @(posedge clk or negedge pg_raw) begin
        if (!pg_raw) q <= 1'b0;
        else         q <= 1'b1;
      end
      assign pg_ok = q;
    end else begin : g_many
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk or negedge pg_raw) begin
        if (!pg_raw) sh <= '0;
        else         sh <= {sh[STAGES-2:0], 1'b1};
      end
      assign pg_ok = sh[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/rstseq_clkdiv.sv
module rstseq_clkdiv #(
  parameter int DIV_LOG2 = 8
) (
  input  logic clk,
  input  logic pg_raw,
  input  logic pg_ok,
  output logic mode_clk,
  output logic tick
);

  localparam int HALF = 2 ** (DIV_LOG2 - 1);
  localparam logic [DIV_LOG2-1:0] TICK_AT = DIV_LOG2'(HALF - 1);
  localparam logic [DIV_LOG2-1:0] WRAP_AT = {DIV_LOG2{1'b1}};

  logic [DIV_LOG2-1:0] cnt;

  always_ff @(posedge clk or negedge pg_raw) begin
    if (!pg_raw)     cnt <= '0;
    else if (!pg_ok) cnt <= '0;
    else             cnt <= cnt + DIV_LOG2'(1);
  end

  assign mode_clk = cnt[DIV_LOG2-1];
  assign tick     = pg_ok && (cnt == TICK_AT);

  // R2
  mclk_steady_chk: assert property (@(posedge clk) disable iff (!pg_ok)
    (cnt != TICK_AT && cnt != WRAP_AT) |=> $stable(mode_clk));

endmodule

// File: rtl/rstseq_loader.sv
module rstseq_loader #(
  parameter int MODE_BITS = 16
) (
  input  logic                 clk,
  input  logic                 pg_raw,
  input  logic                 pg_ok,
  input  logic                 hold,
  input  logic                 tick,
  input  logic                 din,
  output logic [MODE_BITS-1:0] word,
  output logic                 valid
);

  localparam int CW = $clog2(MODE_BITS + 1);
  localparam logic [CW-1:0] LAST = CW'(MODE_BITS - 1);

  logic [CW-1:0]        bit_cnt;
  logic [MODE_BITS-1:0] shifted;

  generate
    if (MODE_BITS == 1) begin : g_single
      assign shifted = din;
    end else begin : g_wide
      assign shifted = {din, word[MODE_BITS-1:1]};
    end
  endgenerate

  always_ff @(posedge clk or negedge pg_raw) begin
    if (!pg_raw) begin
      word    <= '0;
      bit_cnt <= '0;
      valid   <= 1'b0;
    end else if (!pg_ok) begin
      word    <= '0;
      bit_cnt <= '0;
      valid   <= 1'b0;
    end else if (hold) begin
      bit_cnt <= '0;
      valid   <= 1'b0;
    end else if (tick && !valid) begin
      word    <= shifted;
      bit_cnt <= bit_cnt + CW'(1);
      if (bit_cnt == LAST) valid <= 1'b1;
    end
  end

  // R3
  word_only_on_tick_chk: assert property (@(posedge clk) disable iff (!pg_ok)
    !tick |=> $stable(word));

  // R4
  word_frozen_chk: assert property (@(posedge clk) disable iff (!pg_ok)
    valid |=> $stable(word));

endmodule

// File: rtl/rstseq_rstctl.sv
module rstseq_rstctl
  import rstseq_pkg::*;
(
  input  logic clk,
  input  logic pg_raw,
  input  logic pg_ok,
  input  logic cold_rst_n,
  input  logic rst_n,
  input  logic mode_valid,
  output logic core_rst_n,
  output logic rst_is_cold
);

  rst_kind_e kind;
  logic      core_arst_n;

  assign kind        = classify(cold_rst_n, rst_n);
  assign core_arst_n = pg_raw & rst_n;

  // The reset pin clears the release flop directly, so assertion needs no clock.
  always_ff @(posedge clk or negedge core_arst_n) begin
    if (!core_arst_n) core_rst_n <= 1'b0;
    else if (!pg_ok)  core_rst_n <= 1'b0;
    else              core_rst_n <= cold_rst_n & mode_valid;
  end

  always_ff @(posedge clk or negedge pg_raw) begin
    if (!pg_raw)     rst_is_cold <= 1'b1;
    else if (!pg_ok) rst_is_cold <= 1'b1;
    else begin
      case (kind)
        RK_COLD: rst_is_cold <= 1'b1;
        RK_WARM: rst_is_cold <= 1'b0;
        default: rst_is_cold <= rst_is_cold;
      endcase
    end
  end

  // R5
  core_needs_mode_chk: assert property (@(posedge clk) disable iff (!pg_ok)
    core_rst_n |-> mode_valid);

endmodule

// File: rtl/rstseq_top.sv
module rstseq_top #(
  parameter int MODE_BITS   = 16,
  parameter int DIV_LOG2    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 pwr_good,
  input  logic                 cold_rst_n,
  input  logic                 rst_n,
  input  logic                 mode_din,
  output logic                 mode_clk,
  output logic [MODE_BITS-1:0] mode_word,
  output logic                 mode_valid,
  output logic                 rst_is_cold,
  output logic                 core_rst_n
);

  logic pg_ok;
  logic tick;

  rstseq_pg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .pg_raw (pwr_good),
    .pg_ok  (pg_ok)
  );

  rstseq_clkdiv #(.DIV_LOG2(DIV_LOG2)) u_div (
    .clk      (clk),
    .pg_raw   (pwr_good),
    .pg_ok    (pg_ok),
    .mode_clk (mode_clk),
    .tick     (tick)
  );

  rstseq_loader #(.MODE_BITS(MODE_BITS)) u_load (
    .clk    (clk),
    .pg_raw (pwr_good),
    .pg_ok  (pg_ok),
    .hold   (!cold_rst_n),
    .tick   (tick),
    .din    (mode_din),
    .word   (mode_word),
    .valid  (mode_valid)
  );

  rstseq_rstctl u_ctl (
    .clk         (clk),
    .pg_raw      (pwr_good),
    .pg_ok       (pg_ok),
    .cold_rst_n  (cold_rst_n),
    .rst_n       (rst_n),
    .mode_valid  (mode_valid),
    .core_rst_n  (core_rst_n),
    .rst_is_cold (rst_is_cold)
  );

  // R7
  warm_keeps_mode_chk: assert property (@(posedge clk) disable iff (!pg_ok)
    (!rst_n && cold_rst_n && mode_valid) |=> mode_valid);

  // R8
  cold_drops_mode_chk: assert property (@(posedge clk) disable iff (!pg_ok)
    (!rst_n && !cold_rst_n) |=> (!mode_valid && rst_is_cold));

endmodule

// File: tb/sim_rstseq_top.sv
`timescale 1ns/1ps
module sim_rstseq_top;

  localparam int MB = 16;

  logic clk = 1'b0;
  logic pwr_good = 1'b1;
  logic cold_rst_n = 1'b0;
  logic rst_n = 1'b0;
  logic mode_din;
  logic mode_clk, mode_valid, rst_is_cold, core_rst_n;
  logic [MB-1:0] mode_word;

  logic [MB-1:0] rom = 16'hA5C3;
  int rom_idx = 0;
  assign mode_din = rom[rom_idx % MB];

  int checks = 0;
  int fails = 0;
  bit running = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rstseq_top #(.MODE_BITS(MB), .DIV_LOG2(8), .SYNC_STAGES(2)) u0 (
    .clk(clk), .pwr_good(pwr_good), .cold_rst_n(cold_rst_n), .rst_n(rst_n),
    .mode_din(mode_din), .mode_clk(mode_clk), .mode_word(mode_word),
    .mode_valid(mode_valid), .rst_is_cold(rst_is_cold), .core_rst_n(core_rst_n)
  );

  // serial source: next bit presented after each rising mode clock
  always @(posedge mode_clk) begin
    #2;
    rom_idx = rom_idx + 1;
  end

  // behavioural reference
  int m_age, m_div;
  int m_bits;
  bit m_valid, m_cold, m_core;
  logic [MB-1:0] m_word;

  task automatic model_idle();
    m_div = 0; m_bits = 0; m_valid = 0; m_word = '0; m_cold = 1; m_core = 0;
  endtask

  always @(posedge clk or negedge pwr_good) begin
    if (!pwr_good) begin
      m_age = 0;
      model_idle();
    end else begin
      bit ok, n_core;
      ok = (m_age >= 2);
      if (m_age < 2) m_age = m_age + 1;
      if (!ok) model_idle();
      else begin
        n_core = m_valid && cold_rst_n && rst_n;
        if (!rst_n && !cold_rst_n) m_cold = 1;
        else if (!rst_n)           m_cold = 0;
        if (!cold_rst_n) begin
          m_bits = 0; m_valid = 0;
        end else if (!m_valid && m_div == 127) begin
          m_word = {mode_din, m_word[MB-1:1]};
          m_bits = m_bits + 1;
          if (m_bits == MB) m_valid = 1;
        end
        m_div  = (m_div + 1) % 256;
        m_core = n_core;
      end
    end
    running = 1'b1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (running && !done) begin
      chk("R2 mode_clk vs model", {31'd0, mode_clk}, {31'd0, m_div >= 128});
      chk("R3 mode_word vs model", {16'd0, mode_word}, {16'd0, m_word});
      chk("R4 mode_valid vs model", {31'd0, mode_valid}, {31'd0, m_valid});
      chk("R7 rst_is_cold vs model", {31'd0, rst_is_cold}, {31'd0, m_cold});
      chk("R5 core_rst_n vs model", {31'd0, core_rst_n},
          {31'd0, m_core && rst_n && pwr_good});
    end
  end

  task automatic wait_valid(input string tag);
    int n = 0;
    while (!mode_valid && n < 10000) begin
      @(negedge clk);
      n++;
    end
    chk(tag, {31'd0, mode_valid}, 32'd1);
  endtask

  task automatic at_div(input int d);
    do @(negedge clk); while (m_div != d);
    @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    time ta;
    #1 pwr_good = 1'b0;
    repeat (20) @(negedge clk);
    // R1 idle values
    chk("R1 idle mode_clk", {31'd0, mode_clk}, 32'd0);
    chk("R1 idle mode_valid", {31'd0, mode_valid}, 32'd0);
    chk("R1 idle core_rst_n", {31'd0, core_rst_n}, 32'd0);
    chk("R1 idle rst_is_cold", {31'd0, rst_is_cold}, 32'd1);
    cold_rst_n = 1'b1; rst_n = 1'b1;
    for (int i = 0; i < 600; i++) begin
      @(posedge clk); #1 rom_idx = i;
    end
    @(negedge clk);
    chk("R1 nothing loaded before power-good", {16'd0, mode_word}, 32'd0);
    chk("R1 core held in idle", {31'd0, core_rst_n}, 32'd0);

    // power-up load with reset pins held (cold)
    @(posedge clk); #1;
    cold_rst_n = 1'b0; rst_n = 1'b0;
    @(posedge clk); #1;
    cold_rst_n = 1'b1;
    rom = 16'hA5C3; rom_idx = 0; pwr_good = 1'b1;
    @(posedge mode_clk); ta = $time;
    @(posedge mode_clk);
    chk("R2 mode_clk period in clocks", ($time - ta) / 5, 32'd256);
    wait_valid("R4 mode_valid after power-up load");
    chk("R3 LSB-first word after power-up", {16'd0, mode_word}, 32'h0000A5C3);
    repeat (3) @(negedge clk);
    chk("R5 core held while rst_n low", {31'd0, core_rst_n}, 32'd0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R5 core still low before edge", {31'd0, core_rst_n}, 32'd0);
    @(negedge clk);
    chk("R5 core released one edge after pins", {31'd0, core_rst_n}, 32'd1);

    // warm reset across several mode-clock rises
    at_div(50);
    rom = 16'h0000; rst_n = 1'b0;
    #1 chk("R6 core drops without clock", {31'd0, core_rst_n}, 32'd0);
    repeat (600) @(negedge clk);
    chk("R7 warm keeps mode_valid", {31'd0, mode_valid}, 32'd1);
    chk("R7 warm keeps mode_word", {16'd0, mode_word}, 32'h0000A5C3);
    chk("R7 warm flag", {31'd0, rst_is_cold}, 32'd0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R5 core back after warm release", {31'd0, core_rst_n}, 32'd1);

    // cold reset and reload
    @(posedge clk); #1;
    rom = 16'h3C96; cold_rst_n = 1'b0; rst_n = 1'b0;
    repeat (1000) @(negedge clk);
    chk("R8 cold clears mode_valid", {31'd0, mode_valid}, 32'd0);
    chk("R8 cold flag", {31'd0, rst_is_cold}, 32'd1);
    at_div(10);
    cold_rst_n = 1'b1; rst_n = 1'b1; rom_idx = 0;
    wait_valid("R8 reload completes");
    chk("R8 reloaded word", {16'd0, mode_word}, 32'h00003C96);
    chk("R5 core low on valid edge", {31'd0, core_rst_n}, 32'd0);
    @(negedge clk);
    chk("R5 core one edge after valid", {31'd0, core_rst_n}, 32'd1);

    // power loss in the middle of a load
    @(posedge clk); #1 cold_rst_n = 1'b0; rst_n = 1'b0;
    at_div(10);
    cold_rst_n = 1'b1; rst_n = 1'b1; rom_idx = 0;
    repeat (2000) @(negedge clk);
    @(posedge clk); #1 pwr_good = 1'b0;
    #1;
    chk("R9 power loss mode_valid", {31'd0, mode_valid}, 32'd0);
    chk("R9 power loss mode_word", {16'd0, mode_word}, 32'd0);
    chk("R9 power loss core", {31'd0, core_rst_n}, 32'd0);
    chk("R9 power loss flag", {31'd0, rst_is_cold}, 32'd1);
    chk("R9 power loss mode_clk", {31'd0, mode_clk}, 32'd0);
    repeat (50) @(negedge clk);
    @(posedge clk); #1;
    rom = 16'hFFFF; rom_idx = 0; pwr_good = 1'b1;
    wait_valid("R4 valid after power restore");
    chk("R3 all-ones word", {16'd0, mode_word}, 32'h0000FFFF);
    repeat (4) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      summary();
      $finish;
    end
  end

endmodule